// File: doc/BRIEF.md
# Address-Translating Bidirectional Bus Bridge

The block links a primary bus and a secondary bus so that memory-mapped accesses can travel between processing units that sit on different buses. It contains two identical one-way paths. The forward path listens on the primary bus and replays accesses on the secondary bus. The return path listens on the secondary bus and replays accesses on the primary bus.

Each path has its own lookup table of eight entries. An entry has a valid bit, a source address and a destination address, and is written through a shared configuration port. When an access on the listening side matches a valid entry, the path claims it and holds the requesting master in a wait state. It then requests the far bus, waits for the grant, and performs the access there at the mapped destination address. When the far access completes, the path acknowledges the original master and, for a read, returns the far data. An access that matches no valid entry is left alone, so local traffic stays local.

Both capture ports use a valid/ready handshake. A master raises valid with address, write flag and write data, and holds all of them steady until it sees ready high. Ready is the only back-pressure: it stays low for as long as the far access is in flight. The master ports use a request/grant pair plus a valid/ready transfer handshake. Once valid is raised on a master port, the bridge keeps the address, write flag and write data steady until the far side returns ready. Configuration pins are plain, and a write takes effect on the clock edge where `cfg_we` is sampled high.

Top module: `bus_bridge_xlat`

## Requirements
- R1: While reset is asserted and after it is released, the bridge drives every request, master valid and capture ready output low until a capture takes place.
- R2: A configuration write with `cfg_dir` = 0 programs the primary-to-secondary table and `cfg_dir` = 1 programs the secondary-to-primary table, at entry `cfg_idx`. The entry is used for accesses sampled on later edges.
- R3: A captured access is replayed on the far master port with the destination address of the matching entry. The write flag and write data are those of the original access.
- R4: The far request rises two cycles after the capture edge. Master valid rises only on the edge after grant is sampled high, and it is never high without the request.
- R5: An access whose address matches no valid entry of that direction gets no capture ready and raises no far request.
- R6: In the acknowledge cycle, the capture read data equals the far read data for a read and is zero for a write.
- R7: Capture ready is high for exactly one cycle. That cycle is the one after the far valid/ready handshake completes. Before it, the master is held waiting.
- R8: The far request drops in the cycle after the far handshake completes. The path is idle again one cycle later and can accept a new access.
- R9: When several valid entries match, the entry with the lowest index supplies the destination.
- R10: An entry whose valid bit was written as 0 never matches.
- R11: The two directions work independently and may carry accesses at the same time.
- R12: While master valid is high and ready is low, the far address, write flag and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_dir | input | 1 | Table select: 0 forward, 1 return |
| cfg_idx | input | 3 | Entry index |
| cfg_valid | input | 1 | Valid bit written to the entry |
| cfg_src | input | 16 | Source address written to the entry |
| cfg_dst | input | 16 | Destination address written to the entry |
| pri_s_valid | input | 1 | Primary-side access request |
| pri_s_ready | output | 1 | Primary-side access acknowledge |
| pri_s_write | input | 1 | Primary-side access is a write |
| pri_s_addr | input | 16 | Primary-side access address |
| pri_s_wdata | input | 16 | Primary-side write data |
| pri_s_rdata | output | 16 | Read data returned to the primary master |
| pri_m_req | output | 1 | Bus request on the primary bus |
| pri_m_gnt | input | 1 | Bus grant on the primary bus |
| pri_m_valid | output | 1 | Replayed access valid on the primary bus |
| pri_m_ready | input | 1 | Replayed access done on the primary bus |
| pri_m_write | output | 1 | Replayed access is a write |
| pri_m_addr | output | 16 | Translated address on the primary bus |
| pri_m_wdata | output | 16 | Replayed write data |
| pri_m_rdata | input | 16 | Read data from the primary bus |
| sec_s_valid | input | 1 | Secondary-side access request |
| sec_s_ready | output | 1 | Secondary-side access acknowledge |
| sec_s_write | input | 1 | Secondary-side access is a write |
| sec_s_addr | input | 16 | Secondary-side access address |
| sec_s_wdata | input | 16 | Secondary-side write data |
| sec_s_rdata | output | 16 | Read data returned to the secondary master |
| sec_m_req | output | 1 | Bus request on the secondary bus |
| sec_m_gnt | input | 1 | Bus grant on the secondary bus |
| sec_m_valid | output | 1 | Replayed access valid on the secondary bus |
| sec_m_ready | input | 1 | Replayed access done on the secondary bus |
| sec_m_write | output | 1 | Replayed access is a write |
| sec_m_addr | output | 16 | Translated address on the secondary bus |
| sec_m_wdata | output | 16 | Replayed write data |
| sec_m_rdata | input | 16 | Read data from the secondary bus |

## Verification
Counted from the edge that samples a matching access, the far request is due two cycles later. Master valid is due one cycle after the edge that samples grant. Capture ready and the returned data are due one cycle after the edge that samples far ready, and the request is low in that same cycle. The bench advances a behavioural model on each rising edge, using the same input values as the design. It compares every output against the model at the following falling edge, so the comparison always uses the cycle in which each result is due. The far-side grant delay and ready delay are varied, so the wait-state timing is checked both with and without stalls.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPTURE,
    ST_REQUEST,
    ST_TRANSFER,
    ST_RESPOND
  } half_state_e;
endpackage

// File: rtl/xlat_table.sv
module xlat_table #(
  parameter int AW      = 16,
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic                       wr_valid,
  input  logic [AW-1:0]              wr_src,
  input  logic [AW-1:0]              wr_dst,
  input  logic [AW-1:0]              lk_addr,
  output logic                       lk_hit,
  output logic [AW-1:0]              lk_dst
);
  localparam int IW = $clog2(ENTRIES);

  logic              ent_v   [ENTRIES];
  logic [AW-1:0]     ent_src [ENTRIES];
  logic [AW-1:0]     ent_dst [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_v[i]   <= 1'b0;
        ent_src[i] <= '0;
        ent_dst[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_idx == IW'(i)) begin
          ent_v[i]   <= wr_valid;
          ent_src[i] <= wr_src;
          ent_dst[i] <= wr_dst;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_v[g] && (ent_src[g] == lk_addr);
  end

  // Scan downward so the lowest matching index is the last to win
  always_comb begin
    lk_hit = |match;
    lk_dst = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) lk_dst = ent_dst[i];
    end
  end
endmodule

// File: rtl/bridge_half.sv
module bridge_half
  import bridge_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          s_write,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  output logic [DW-1:0] s_rdata,
  output logic          m_req,
  input  logic          m_gnt,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  output logic [AW-1:0] lk_addr,
  input  logic          lk_hit,
  input  logic [AW-1:0] lk_dst
);
  half_state_e   state;
  logic [AW-1:0] cap_addr;
  logic          cap_write;
  logic [DW-1:0] cap_wdata;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] rdata_q;

  assign lk_addr = (state == ST_IDLE) ? s_addr : cap_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cap_addr  <= '0;
      cap_write <= 1'b0;
      cap_wdata <= '0;
      out_addr  <= '0;
      rdata_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (s_valid && lk_hit) begin
          cap_addr  <= s_addr;
          cap_write <= s_write;
          cap_wdata <= s_wdata;
          state     <= ST_CAPTURE;
        end
        ST_CAPTURE: begin
          out_addr <= lk_dst;
          state    <= ST_REQUEST;
        end
        ST_REQUEST: if (m_gnt) state <= ST_TRANSFER;
        ST_TRANSFER: if (m_ready) begin
          rdata_q <= cap_write ? '0 : m_rdata;
          state   <= ST_RESPOND;
        end
        ST_RESPOND: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign m_req   = (state == ST_REQUEST) || (state == ST_TRANSFER);
  assign m_valid = (state == ST_TRANSFER);
  assign m_addr  = out_addr;
  assign m_write = cap_write;
  assign m_wdata = cap_wdata;
  assign s_ready = (state == ST_RESPOND);
  assign s_rdata = rdata_q;

  AST_DRIVE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $rose(m_valid) |-> $past(m_gnt)); // R4
  AST_VALID_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n) m_valid |-> m_req); // R4
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (m_valid && m_ready) |=> (!m_req && s_ready)); // R8
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata))); // R12
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) s_ready |=> !s_ready); // R7
  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) s_ready |-> $past(m_valid && m_ready)); // R7
endmodule

// File: rtl/bus_bridge_xlat.sv
module bus_bridge_xlat #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_dir,
  input  logic [$clog2(ENTRIES)-1:0] cfg_idx,
  input  logic                       cfg_valid,
  input  logic [AW-1:0]              cfg_src,
  input  logic [AW-1:0]              cfg_dst,
  input  logic                       pri_s_valid,
  output logic                       pri_s_ready,
  input  logic                       pri_s_write,
  input  logic [AW-1:0]              pri_s_addr,
  input  logic [DW-1:0]              pri_s_wdata,
  output logic [DW-1:0]              pri_s_rdata,
  output logic                       pri_m_req,
  input  logic                       pri_m_gnt,
  output logic                       pri_m_valid,
  input  logic                       pri_m_ready,
  output logic                       pri_m_write,
  output logic [AW-1:0]              pri_m_addr,
  output logic [DW-1:0]              pri_m_wdata,
  input  logic [DW-1:0]              pri_m_rdata,
  input  logic                       sec_s_valid,
  output logic                       sec_s_ready,
  input  logic                       sec_s_write,
  input  logic [AW-1:0]              sec_s_addr,
  input  logic [DW-1:0]              sec_s_wdata,
  output logic [DW-1:0]              sec_s_rdata,
  output logic                       sec_m_req,
  input  logic                       sec_m_gnt,
  output logic                       sec_m_valid,
  input  logic                       sec_m_ready,
  output logic                       sec_m_write,
  output logic [AW-1:0]              sec_m_addr,
  output logic [DW-1:0]              sec_m_wdata,
  input  logic [DW-1:0]              sec_m_rdata
);
  localparam int NDIR = 2;

  logic [AW-1:0] lk_addr [NDIR];
  logic          lk_hit  [NDIR];
  logic [AW-1:0] lk_dst  [NDIR];

  // Table 0 serves the forward path, table 1 the return path (R2)
  for (genvar d = 0; d < NDIR; d++) begin : g_tab
    xlat_table #(.AW(AW), .ENTRIES(ENTRIES)) u_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_dir == 1'(d))),
      .wr_idx   (cfg_idx),
      .wr_valid (cfg_valid),
      .wr_src   (cfg_src),
      .wr_dst   (cfg_dst),
      .lk_addr  (lk_addr[d]),
      .lk_hit   (lk_hit[d]),
      .lk_dst   (lk_dst[d])
    );
  end

  bridge_half #(.AW(AW), .DW(DW)) u_fwd (
    .clk (clk), .rst_n (rst_n),
    .s_valid (pri_s_valid), .s_ready (pri_s_ready), .s_write (pri_s_write),
    .s_addr (pri_s_addr), .s_wdata (pri_s_wdata), .s_rdata (pri_s_rdata),
    .m_req (sec_m_req), .m_gnt (sec_m_gnt), .m_valid (sec_m_valid),
    .m_ready (sec_m_ready), .m_write (sec_m_write), .m_addr (sec_m_addr),
    .m_wdata (sec_m_wdata), .m_rdata (sec_m_rdata),
    .lk_addr (lk_addr[0]), .lk_hit (lk_hit[0]), .lk_dst (lk_dst[0])
  );

  bridge_half #(.AW(AW), .DW(DW)) u_ret (
    .clk (clk), .rst_n (rst_n),
    .s_valid (sec_s_valid), .s_ready (sec_s_ready), .s_write (sec_s_write),
    .s_addr (sec_s_addr), .s_wdata (sec_s_wdata), .s_rdata (sec_s_rdata),
    .m_req (pri_m_req), .m_gnt (pri_m_gnt), .m_valid (pri_m_valid),
    .m_ready (pri_m_ready), .m_write (pri_m_write), .m_addr (pri_m_addr),
    .m_wdata (pri_m_wdata), .m_rdata (pri_m_rdata),
    .lk_addr (lk_addr[1]), .lk_hit (lk_hit[1]), .lk_dst (lk_dst[1])
  );
endmodule

// File: tb/test_bus_bridge_xlat.sv
module test_bus_bridge_xlat;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int N  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cfg_we = 1'b0, cfg_dir = 1'b0, cfg_valid = 1'b0;
  logic [2:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;

  logic          sv [2], sw [2], gnt [2], mrdy [2];
  logic [AW-1:0] sa [2];
  logic [DW-1:0] swd [2], mrd [2];
  logic          srdy [2], mreq [2], mval [2], mwr [2];
  logic [DW-1:0] srd [2], mwd [2];
  logic [AW-1:0] mad [2];

  bus_bridge_xlat #(.AW(AW), .DW(DW), .ENTRIES(N)) i_bus_bridge_xlat (
    .clk (clk), .rst_n (rst_n),
    .cfg_we (cfg_we), .cfg_dir (cfg_dir), .cfg_idx (cfg_idx), .cfg_valid (cfg_valid),
    .cfg_src (cfg_src), .cfg_dst (cfg_dst),
    .pri_s_valid (sv[0]), .pri_s_ready (srdy[0]), .pri_s_write (sw[0]),
    .pri_s_addr (sa[0]), .pri_s_wdata (swd[0]), .pri_s_rdata (srd[0]),
    .pri_m_req (mreq[1]), .pri_m_gnt (gnt[1]), .pri_m_valid (mval[1]),
    .pri_m_ready (mrdy[1]), .pri_m_write (mwr[1]), .pri_m_addr (mad[1]),
    .pri_m_wdata (mwd[1]), .pri_m_rdata (mrd[1]),
    .sec_s_valid (sv[1]), .sec_s_ready (srdy[1]), .sec_s_write (sw[1]),
    .sec_s_addr (sa[1]), .sec_s_wdata (swd[1]), .sec_s_rdata (srd[1]),
    .sec_m_req (mreq[0]), .sec_m_gnt (gnt[0]), .sec_m_valid (mval[0]),
    .sec_m_ready (mrdy[0]), .sec_m_write (mwr[0]), .sec_m_addr (mad[0]),
    .sec_m_wdata (mwd[0]), .sec_m_rdata (mrd[0])
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 captured, 2 requesting, 3 driving, 4 acknowledging
  int            ph [2];
  logic [AW-1:0] e_dst [2];
  logic          e_wr [2];
  logic [DW-1:0] e_wd [2], e_rd [2];
  logic          tv [2][N];
  logic [AW-1:0] tsrc [2][N], tdst [2][N];
  int            hit_i;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        ph[d] = 0; e_rd[d] = '0; e_dst[d] = '0; e_wr[d] = 1'b0; e_wd[d] = '0;
        for (int i = 0; i < N; i++) begin tv[d][i] = 1'b0; tsrc[d][i] = '0; tdst[d][i] = '0; end
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (ph[d] == 0) begin
          if (sv[d] === 1'b1) begin
            hit_i = -1;
            for (int i = 0; i < N; i++)
              if (hit_i < 0 && tv[d][i] && tsrc[d][i] == sa[d]) hit_i = i;
            if (hit_i >= 0) begin
              e_dst[d] = tdst[d][hit_i]; e_wr[d] = sw[d]; e_wd[d] = swd[d]; ph[d] = 1;
            end
          end
        end else if (ph[d] == 1) ph[d] = 2;
        else if (ph[d] == 2) begin if (gnt[d]) ph[d] = 3; end
        else if (ph[d] == 3) begin
          if (mrdy[d]) begin e_rd[d] = e_wr[d] ? '0 : mrd[d]; ph[d] = 4; end
        end else ph[d] = 0;
      end
      if (cfg_we) begin
        tv[cfg_dir][cfg_idx] = cfg_valid; tsrc[cfg_dir][cfg_idx] = cfg_src; tdst[cfg_dir][cfg_idx] = cfg_dst;
      end
    end
  end

  // Compare every output against the model once per cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < 2; d++) begin
        chk($sformatf("R4 request dir%0d", d), 32'(mreq[d]), 32'(ph[d] == 2 || ph[d] == 3));
        chk($sformatf("R4 master valid dir%0d", d), 32'(mval[d]), 32'(ph[d] == 3));
        if (ph[d] == 3) begin
          chk($sformatf("R3 R12 far address dir%0d", d), 32'(mad[d]), 32'(e_dst[d]));
          chk($sformatf("R3 far write flag dir%0d", d), 32'(mwr[d]), 32'(e_wr[d]));
          chk($sformatf("R3 far write data dir%0d", d), 32'(mwd[d]), 32'(e_wd[d]));
        end
        chk($sformatf("R7 capture ready dir%0d", d), 32'(srdy[d]), 32'(ph[d] == 4));
        if (ph[d] == 4) chk($sformatf("R6 returned data dir%0d", d), 32'(srd[d]), 32'(e_rd[d]));
      end
    end
  end

  // Far-side arbiter and slave with adjustable delays
  int gc [2], vc [2], gdly [2], rdly [2];
  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (mreq[d] !== 1'b1) begin gc[d] = 0; gnt[d] = 1'b0; end
      else begin gnt[d] = (gc[d] >= gdly[d]); gc[d]++; end
      if (mval[d] !== 1'b1) begin vc[d] = 0; mrdy[d] = 1'b0; mrd[d] = '0; end
      else begin mrdy[d] = (vc[d] >= rdly[d]); mrd[d] = mad[d] ^ 16'h5A3C; vc[d]++; end
    end
  end

  task automatic prog(input logic dir, input int idx, input logic v, input logic [AW-1:0] src, input logic [AW-1:0] dst);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dir = dir; cfg_idx = 3'(idx); cfg_valid = v; cfg_src = src; cfg_dst = dst;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input int d, input logic [AW-1:0] addr, input logic wr, input logic [DW-1:0] wd,
                        input bit hit, input logic [AW-1:0] dst, input string tag);
    logic [AW-1:0] seen;
    int k;
    seen = '0;
    @(negedge clk);
    sv[d] = 1'b1; sa[d] = addr; sw[d] = wr; swd[d] = wd;
    if (hit) begin
      k = 0;
      do begin
        @(negedge clk);
        if (mval[d] === 1'b1) seen = mad[d];
        k++;
      end while (srdy[d] !== 1'b1 && k < 40);
      chk({tag, " R7 acknowledged"}, 32'(srdy[d]), 32'd1);
      chk({tag, " R8 request low at acknowledge"}, 32'(mreq[d]), 32'd0);
      chk({tag, " R3 translated address"}, 32'(seen), 32'(dst));
      if (!wr) chk({tag, " R6 read data"}, 32'(srd[d]), 32'(dst ^ 16'h5A3C));
      else     chk({tag, " R6 zero on write"}, 32'(srd[d]), 32'd0);
    end else begin
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        chk({tag, " R5 no acknowledge"}, 32'(srdy[d]), 32'd0);
        chk({tag, " R5 no request"}, 32'(mreq[d]), 32'd0);
      end
    end
    sv[d] = 1'b0;
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      sv[d] = 1'b0; sw[d] = 1'b0; sa[d] = '0; swd[d] = '0;
      gnt[d] = 1'b0; mrdy[d] = 1'b0; mrd[d] = '0; gdly[d] = 0; rdly[d] = 0;
    end
    fork
      begin
        repeat (3) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
          chk("R1 request in reset", 32'(mreq[d]), 32'd0);
          chk("R1 valid in reset", 32'(mval[d]), 32'd0);
          chk("R1 ready in reset", 32'(srdy[d]), 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 request after reset", 32'(mreq[0]) | 32'(mreq[1]), 32'd0);
        // R2: forward table entries, used right after programming
        prog(1'b0, 0, 1'b1, 16'h1000, 16'h8000);
        prog(1'b0, 3, 1'b1, 16'h1004, 16'h8040);
        access(0, 16'h1000, 1'b1, 16'hBEEF, 1'b1, 16'h8000, "R2 write");
        access(0, 16'h1004, 1'b0, 16'h0000, 1'b1, 16'h8040, "R2 read");
        // R8: back-to-back with stalls on grant and ready
        gdly[0] = 3; rdly[0] = 2;
        access(0, 16'h1000, 1'b0, 16'h0000, 1'b1, 16'h8000, "R8 stalled read");
        access(0, 16'h1004, 1'b1, 16'h1234, 1'b1, 16'h8040, "R12 stalled write");
        // R5: unmapped address, and return table not yet holding it
        access(0, 16'h2000, 1'b0, 16'h0000, 1'b0, 16'h0000, "R5 forward miss");
        access(1, 16'h1000, 1'b0, 16'h0000, 1'b0, 16'h0000, "R5 return miss");
        // R9: two matching entries, lowest index wins
        prog(1'b0, 6, 1'b1, 16'h3000, 16'h9600);
        prog(1'b0, 2, 1'b1, 16'h3000, 16'h9200);
        access(0, 16'h3000, 1'b0, 16'h0000, 1'b1, 16'h9200, "R9 priority");
        // R10: clearing the valid bit removes the entry
        prog(1'b0, 2, 1'b0, 16'h3000, 16'h9200);
        access(0, 16'h3000, 1'b0, 16'h0000, 1'b1, 16'h9600, "R10 fallback");
        prog(1'b0, 7, 1'b0, 16'h4000, 16'hA000);
        access(0, 16'h4000, 1'b0, 16'h0000, 1'b0, 16'h0000, "R10 invalid entry");
        // R11: return direction alone, then both at once
        prog(1'b1, 1, 1'b1, 16'h8000, 16'h1100);
        prog(1'b1, 5, 1'b1, 16'h8800, 16'h1580);
        access(1, 16'h8000, 1'b0, 16'h0000, 1'b1, 16'h1100, "R11 return read");
        gdly[1] = 1; rdly[1] = 4; gdly[0] = 0; rdly[0] = 1;
        fork
          access(0, 16'h1004, 1'b0, 16'h0000, 1'b1, 16'h8040, "R11 concurrent fwd");
          access(1, 16'h8800, 1'b1, 16'hCAFE, 1'b1, 16'h1580, "R11 concurrent ret");
        join
        repeat (4) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired, actual=running expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule